// File: doc/BRIEF.md
# Four-Channel PWM Generator with Shadowed Reload

This block produces four independent pulse-width-modulated outputs. Each channel counts prescaled ticks of an externally supplied 1 MHz timing strobe. Every channel has a 16-bit period, a 16-bit duty value and a small control word. The control word picks a power-of-two prescaler (divide by 1, 2, 4 or 8) and selects whether the output is inverted. A word-aligned write/read bus reaches the registers, and reads are combinational from the address.

Reconfiguring a running channel never tears a period. Duty and control writes land in shadow copies. Writing the period register arms a reload, and the shadow set becomes live in one step when the period that is running ends. Writing a zero period arms a shutdown that takes effect at the same boundary. From then on the output is held low whatever the polarity. An idle channel that receives a nonzero period starts at once.

Top module: `pwm_bank_shadow`

## Requirements
- R1: After an active-low synchronous reset, every channel is disabled, every output is low and every register reads as zero.
- R2: Registers sit at byte addresses 0x400+4·ch (period), 0x420+4·ch (duty) and 0x440+4·ch (control), for ch = 0..3. Control bits [1:0] hold the prescale code and bit 5 holds the polarity. A read returns the committed values, not the pending shadow values.
- R3: With normal polarity the output is high while the channel counter is below duty and low for the rest of the period. The counter advances once per divisor ticks and wraps to 0 after period−1.
- R4: Prescale code 0, 1, 2 or 3 makes the counter advance once every 1, 2, 4 or 8 ticks.
- R5: When control bit 5 is set, the active level is low and the inactive level is high.
- R6: A duty of 0 leaves the output inactive for the whole period. A duty equal to the period leaves it active for the whole period.
- R7: An idle channel loads a nonzero period write in that clock cycle, together with the shadow duty and control. The counter is 0 right after the write edge, and the first step comes on the next tick.
- R8: On a running channel, duty and control writes change neither the output nor the read values. They take effect together with a written period at the first period boundary after that period write.
- R9: Writing 0 to the period of a running channel lets the current period finish. The channel then holds its output low and its period reads 0.
- R10: A write to one channel does not change the output pattern of any other channel.
- R11: With the tick input low, no counter moves and every output holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe of the 1 MHz timing base |
| wrEn | input | 1 | Register write strobe |
| busAddr | input | 11 | Byte address for reads and writes |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Committed value at busAddr (0 if unmapped) |
| pwmOut | output | 4 | PWM outputs, one per channel |

## Verification
A corrupt counter or prescale count shows at the pin as a high or low phase of the wrong length within one period. A bad committed register shows the same way, and a read of that register also shows it at once. A shadow value that leaks early changes the output pattern and the duty or control readback in the same cycle, before the boundary has passed. A lost arm flag shows as a period boundary at which neither the new pattern nor the shutdown appears. All of these are seen by sampling the outputs every cycle against a model built from the write cycle.

// File: rtl/pwm_bank_pkg.sv
`timescale 1ns/1ps
package pwm_bank_pkg;
  localparam int DATA_W     = 16;
  localparam int PRE_W      = 2;
  localparam int ADDR_W     = 11;
  localparam int DIV_CNT_W  = (1 << PRE_W) - 1;
  localparam int INV_BIT    = 5;

  // bus decode -> channel sequencer
  typedef struct packed {
    logic wrPeriod;
    logic wrDuty;
    logic wrCtrl;
  } busStrobe_t;

  // channel sequencer -> channel datapath
  typedef struct packed {
    logic ldShPeriod;
    logic ldShDuty;
    logic ldShCtrl;
    logic loadIdle;
    logic commit;
    logic restart;
    logic advance;
    logic preInc;
    logic arm;
    logic disarm;
  } seqStrobe_t;

  // channel datapath -> channel sequencer
  typedef struct packed {
    logic idle;
    logic divDone;
    logic cntLast;
    logic armed;
  } chanStatus_t;
endpackage

// File: rtl/pwm_bus_if.sv
`timescale 1ns/1ps
module pwm_bus_if
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                         wrEn,
  input  logic [ADDR_W-1:0]            busAddr,
  output logic [DATA_W-1:0]            rdData,
  output busStrobe_t [NCH-1:0]         chStrobe,
  input  logic [NCH-1:0][DATA_W-1:0]   curPeriodV,
  input  logic [NCH-1:0][DATA_W-1:0]   curDutyV,
  input  logic [NCH-1:0][PRE_W-1:0]    curPreV,
  input  logic [NCH-1:0]               curInvV
);
  // window 0x400..0x47F, three groups of eight words
  logic       hit;
  logic [1:0] grp;
  logic [2:0] chSel;

  assign hit   = (busAddr[10:7] == 4'b1000) && (busAddr[1:0] == 2'b00);
  assign grp   = busAddr[6:5];
  assign chSel = busAddr[4:2];

  for (genvar c = 0; c < NCH; c++) begin : g_stb
    logic sel;
    assign sel = wrEn && hit && (chSel == 3'(c));
    assign chStrobe[c] = '{wrPeriod: sel && (grp == 2'd0),
                           wrDuty:   sel && (grp == 2'd1),
                           wrCtrl:   sel && (grp == 2'd2)};
  end

  always_comb begin
    rdData = '0;
    if (hit) begin
      for (int c = 0; c < NCH; c++) begin
        if (chSel == 3'(c)) begin
          case (grp)
            2'd0: rdData = curPeriodV[c];
            2'd1: rdData = curDutyV[c];
            2'd2: begin
              rdData[INV_BIT]   = curInvV[c];
              rdData[PRE_W-1:0] = curPreV[c];
            end
            default: rdData = '0;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/pwm_chan_ctrl.sv
`timescale 1ns/1ps
module pwm_chan_ctrl
  import pwm_bank_pkg::*;
(
  input  logic        tick,
  input  busStrobe_t  busStb,
  input  logic        wrNonZero,
  input  chanStatus_t stat,
  output seqStrobe_t  seq
);
  logic running;
  logic step;
  logic endPer;
  logic loadNow;
  logic commitNow;

  assign running   = !stat.idle;
  assign step      = tick && running && stat.divDone;
  assign endPer    = step && stat.cntLast;
  assign loadNow   = stat.idle && busStb.wrPeriod && wrNonZero;
  assign commitNow = endPer && stat.armed;

  always_comb begin
    seq.ldShPeriod = busStb.wrPeriod;
    seq.ldShDuty   = busStb.wrDuty;
    seq.ldShCtrl   = busStb.wrCtrl;
    seq.loadIdle   = loadNow;
    seq.commit     = commitNow;
    seq.restart    = endPer || loadNow;
    seq.advance    = step && !stat.cntLast;
    seq.preInc     = tick && running && !stat.divDone;
    seq.arm        = busStb.wrPeriod && running;
    seq.disarm     = commitNow || loadNow;
  end
endmodule

// File: rtl/pwm_chan_dp.sv
`timescale 1ns/1ps
module pwm_chan_dp
  import pwm_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        seq,
  input  logic [DATA_W-1:0] wrWord,
  input  logic [PRE_W-1:0]  wrPre,
  input  logic              wrInv,
  output chanStatus_t       stat,
  output logic [DATA_W-1:0] curPeriod,
  output logic [DATA_W-1:0] curDuty,
  output logic [PRE_W-1:0]  curPre,
  output logic              curInv,
  output logic              pwmOut
);
  logic [DATA_W-1:0]    shPeriod;
  logic [DATA_W-1:0]    shDuty;
  logic [PRE_W-1:0]     shPre;
  logic                 shInv;
  logic                 armed;
  logic [DATA_W-1:0]    cnt;
  logic [DIV_CNT_W-1:0] preCnt;
  logic [DIV_CNT_W-1:0] divMax;

  assign divMax = DIV_CNT_W'((1 << curPre) - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shPeriod  <= '0;
      shDuty    <= '0;
      shPre     <= '0;
      shInv     <= 1'b0;
      curPeriod <= '0;
      curDuty   <= '0;
      curPre    <= '0;
      curInv    <= 1'b0;
      armed     <= 1'b0;
      cnt       <= '0;
      preCnt    <= '0;
    end else begin
      if (seq.ldShPeriod) shPeriod <= wrWord;
      if (seq.ldShDuty)   shDuty   <= wrWord;
      if (seq.ldShCtrl) begin
        shPre <= wrPre;
        shInv <= wrInv;
      end

      if (seq.loadIdle) begin
        curPeriod <= wrWord;
        curDuty   <= shDuty;
        curPre    <= shPre;
        curInv    <= shInv;
      end else if (seq.commit) begin
        curPeriod <= shPeriod;
        curDuty   <= shDuty;
        curPre    <= shPre;
        curInv    <= shInv;
      end

      if (seq.restart) begin
        cnt    <= '0;
        preCnt <= '0;
      end else if (seq.advance) begin
        cnt    <= cnt + 1'b1;
        preCnt <= '0;
      end else if (seq.preInc) begin
        preCnt <= preCnt + 1'b1;
      end

      if (seq.arm)         armed <= 1'b1;
      else if (seq.disarm) armed <= 1'b0;
    end
  end

  assign stat.idle    = (curPeriod == '0);
  assign stat.divDone = (preCnt == divMax);
  assign stat.cntLast = (cnt == curPeriod - 1'b1);
  assign stat.armed   = armed;

  assign pwmOut = !stat.idle && ((cnt < curDuty) ^ curInv);
endmodule

// File: rtl/pwm_bank_shadow.sv
`timescale 1ns/1ps
module pwm_bank_shadow
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NCH-1:0]    pwmOut
);
  busStrobe_t [NCH-1:0]       chStrobe;
  logic [NCH-1:0][DATA_W-1:0] curPeriodV;
  logic [NCH-1:0][DATA_W-1:0] curDutyV;
  logic [NCH-1:0][PRE_W-1:0]  curPreV;
  logic [NCH-1:0]             curInvV;
  logic                       wrNonZero;

  assign wrNonZero = |wrData;

  pwm_bus_if #(.NCH(NCH)) bus_i (
    .wrEn       (wrEn),
    .busAddr    (busAddr),
    .rdData     (rdData),
    .chStrobe   (chStrobe),
    .curPeriodV (curPeriodV),
    .curDutyV   (curDutyV),
    .curPreV    (curPreV),
    .curInvV    (curInvV)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    seqStrobe_t  seq;
    chanStatus_t stat;

    pwm_chan_ctrl ctrl_i (
      .tick      (tick),
      .busStb    (chStrobe[c]),
      .wrNonZero (wrNonZero),
      .stat      (stat),
      .seq       (seq)
    );

    pwm_chan_dp dp_i (
      .clk       (clk),
      .rstN      (rstN),
      .seq       (seq),
      .wrWord    (wrData),
      .wrPre     (wrData[PRE_W-1:0]),
      .wrInv     (wrData[INV_BIT]),
      .stat      (stat),
      .curPeriod (curPeriodV[c]),
      .curDuty   (curDutyV[c]),
      .curPre    (curPreV[c]),
      .curInv    (curInvV[c]),
      .pwmOut    (pwmOut[c])
    );
  end
endmodule

// File: rtl/pwm_bank_checker.sv
`timescale 1ns/1ps
module pwm_bank_checker
  import pwm_bank_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       tick,
  input logic [NCH-1:0]             pwmOut,
  input logic [NCH-1:0][DATA_W-1:0] curPeriodV,
  input logic [NCH-1:0][DATA_W-1:0] curDutyV,
  input logic [NCH-1:0]             curInvV
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rstN)
      !$past(rstN) |-> (!pwmOut[c] && curPeriodV[c] == '0));

    assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rstN)
      (curPeriodV[c] == '0) |-> !pwmOut[c]);

    assert_full_duty_R6: assert property (@(posedge clk) disable iff (!rstN)
      (curPeriodV[c] != '0 && curDutyV[c] >= curPeriodV[c]) |-> (pwmOut[c] == !curInvV[c]));

    assert_zero_duty_R6: assert property (@(posedge clk) disable iff (!rstN)
      (curPeriodV[c] != '0 && curDutyV[c] == '0) |-> (pwmOut[c] == curInvV[c]));

    assert_no_tick_frozen_R11: assert property (@(posedge clk) disable iff (!rstN)
      (!tick && curPeriodV[c] != '0) |=>
        ($stable(curPeriodV[c]) && $stable(curDutyV[c]) && $stable(curInvV[c]) && $stable(pwmOut[c])));
  end
endmodule

bind pwm_bank_shadow pwm_bank_checker #(.NCH(NCH)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .tick       (tick),
  .pwmOut     (pwmOut),
  .curPeriodV (curPeriodV),
  .curDutyV   (curDutyV),
  .curInvV    (curInvV)
);

// File: tb/pwm_bank_shadow_tb_top.sv
`timescale 1ns/1ps
module pwm_bank_shadow_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b1;
  logic        wrEn = 1'b0;
  logic [10:0] busAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [3:0]  pwmOut;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 0;

  pwm_bank_shadow dut_i (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn),
    .busAddr(busAddr), .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [10:0] aPer(int ch);  return 11'(32'h400 + 4*ch); endfunction
  function automatic logic [10:0] aDut(int ch);  return 11'(32'h420 + 4*ch); endfunction
  function automatic logic [10:0] aCtl(int ch);  return 11'(32'h440 + 4*ch); endfunction

  task automatic busWrite(input logic [10:0] a, input logic [15:0] d);
    busAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic checkRead(input string tag, input logic [10:0] a, input logic [15:0] exp);
    logic [15:0] v;
    busAddr = a;
    #1;
    v = rdData;
    checks++;
    if (v !== exp) begin
      fails++;
      $display("FAIL %s: read 0x%03h got 0x%04h expected 0x%04h", tag, a, v, exp);
    end
  endtask

  // compare one output over n cycles against the period/duty model
  task automatic runCompare(input string tag, input int ch, input int n, input int base,
                            input int per, input int duty, input int dv, input bit inv);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      logic e;
      e = ((((cyc - base) / dv) % per) < duty) ^ inv;
      if (!bad && pwmOut[ch] !== e) begin
        bad = 1;
        $display("FAIL %s: ch%0d cycle %0d got %b expected %b", tag, ch, cyc - base, pwmOut[ch], e);
      end
      @(negedge clk);
    end
    checks++;
    if (bad) fails++;
  endtask

  task automatic runConst(input string tag, input int ch, input int n, input logic e);
    bit bad = 0;
    for (int i = 0; i < n; i++) begin
      if (!bad && pwmOut[ch] !== e) begin
        bad = 1;
        $display("FAIL %s: ch%0d got %b expected %b", tag, ch, pwmOut[ch], e);
      end
      @(negedge clk);
    end
    checks++;
    if (bad) fails++;
  endtask

  int c0, c1, b1, b2, d0, d3;

  task automatic testReset();
    bit bad = 0;
    for (int ch = 0; ch < 4; ch++) begin
      checkRead("R1 period", aPer(ch), 16'h0);
      checkRead("R1 duty",   aDut(ch), 16'h0);
      checkRead("R1 ctrl",   aCtl(ch), 16'h0);
    end
    for (int i = 0; i < 5; i++) begin
      if (pwmOut !== 4'b0) bad = 1;
      @(negedge clk);
    end
    checks++;
    if (bad) begin fails++; $display("FAIL R1: outputs got %b expected 0000", pwmOut); end
  endtask

  task automatic testIdleLoad();
    busWrite(aDut(0), 16'd3);
    busWrite(aCtl(0), 16'h0);
    busWrite(aPer(0), 16'd10);
    c0 = cyc;
    checkRead("R7 R2 period live", aPer(0), 16'd10);
    checkRead("R7 R2 duty live", aDut(0), 16'd3);
    runCompare("R3 R7 normal pattern", 0, 25, c0, 10, 3, 1, 1'b0);
  endtask

  task automatic testShadow();
    busWrite(aDut(0), 16'd4);
    busWrite(aCtl(0), 16'h0020);
    busWrite(aPer(0), 16'd6);
    c1 = c0 + 10 * ((cyc - c0) / 10 + 1);
    checkRead("R8 duty not yet", aDut(0), 16'd3);
    checkRead("R8 ctrl not yet", aCtl(0), 16'h0);
    checkRead("R8 period not yet", aPer(0), 16'd10);
    runCompare("R8 old pattern kept", 0, c1 - cyc, c0, 10, 3, 1, 1'b0);
    checkRead("R8 R2 period committed", aPer(0), 16'd6);
    checkRead("R8 R2 duty committed", aDut(0), 16'd4);
    checkRead("R8 R5 ctrl committed", aCtl(0), 16'h0020);
    runCompare("R5 R8 inverted new pattern", 0, 30, c1, 6, 4, 1, 1'b1);
  endtask

  task automatic testPrescale();
    busWrite(aCtl(1), 16'd2);
    busWrite(aDut(1), 16'd2);
    busWrite(aPer(1), 16'd5);
    b1 = cyc;
    runCompare("R4 divide by 4", 1, 60, b1, 5, 2, 4, 1'b0);
    busWrite(aCtl(2), 16'd3);
    busWrite(aDut(2), 16'd1);
    busWrite(aPer(2), 16'd3);
    b2 = cyc;
    runCompare("R4 divide by 8", 2, 48, b2, 3, 1, 8, 1'b0);
  endtask

  task automatic testDisable();
    int c2;
    busWrite(aPer(0), 16'd0);
    c2 = c1 + 6 * ((cyc - c1) / 6 + 1);
    checkRead("R9 period before end", aPer(0), 16'd6);
    runCompare("R9 period runs out", 0, c2 - cyc, c1, 6, 4, 1, 1'b1);
    runConst("R9 held low", 0, 20, 1'b0);
    checkRead("R9 period cleared", aPer(0), 16'd0);
  endtask

  task automatic testDutyEdges();
    busWrite(aCtl(0), 16'h0);
    busWrite(aDut(0), 16'd0);
    busWrite(aPer(0), 16'd7);
    d0 = cyc;
    busWrite(aCtl(3), 16'h0);
    busWrite(aDut(3), 16'd3);
    busWrite(aPer(3), 16'd3);
    d3 = cyc;
    runCompare("R6 zero duty", 0, 20, d0, 7, 0, 1, 1'b0);
    runCompare("R6 full duty", 3, 20, d3, 3, 3, 1, 1'b0);
    runCompare("R10 ch1 undisturbed", 1, 20, b1, 5, 2, 4, 1'b0);
    runCompare("R10 ch2 undisturbed", 2, 20, b2, 3, 1, 8, 1'b0);
  endtask

  task automatic testTickHold();
    logic [3:0] snap;
    bit bad = 0;
    tick = 1'b0;
    snap = pwmOut;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!bad && pwmOut !== snap) begin
        bad = 1;
        $display("FAIL R11: outputs got %b expected %b", pwmOut, snap);
      end
    end
    checks++;
    if (bad) fails++;
    tick = 1'b1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testIdleLoad();
    testShadow();
    testPrescale();
    testDisable();
    testDutyEdges();
    testTickHold();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule